// File: doc/BRIEF.md
# Vertical Blanking and Field Parity Generator

This block sits behind a sync separator that has already qualified the horizontal line strobe and the vertical sync signal. It counts line strobes between vertical leading edges and captures that count as a lines-per-frame value, with a flag that marks a fresh capture. From these counts it builds a vertical blanking window around each vertical leading edge.

The window opens a programmable number of lines before the edge and closes a programmable number of lines after it. The block cannot see the edge in advance, so it predicts the opening from the frame length it captured last time.

It also produces a field parity output. The parity is taken from where the vertical leading edge falls within a line. The output changes on the trailing edge of vertical sync by default, or on the leading edge when a mode bit selects that. For progressive sources the parity output is forced high.

Top module: `vblank_field_gen`

## Requirements
- R1: While reset is asserted and after its release, `vblank`, `oddEven`, `linesPerFrame` and `lpfUpdated` are all 0 until the first input event.
- R2: On the cycle after a rising edge of `vsyncIn` is sampled, `linesPerFrame` holds the number of `lineStb` pulses seen since the previous rising edge, including a pulse in the edge cycle itself, and `lpfUpdated` is 1. `lpfUpdated` returns to 0 after the next `lineStb` that has no rising edge in the same cycle. `linesPerFrame` changes only on such captures.
- R3: The line count saturates at its all-ones value (255 for an 8-bit counter) and does not wrap.
- R4: When blanking is enabled, `vblank` is 1 on the cycle after a vertical rising edge if `linesAfter` is non-zero. It falls after the `linesAfter`-th subsequent `lineStb`. With `linesAfter` = 0 it is 0 after the edge.
- R5: When a previous capture exists and `linesBefore` is non-zero, `vblank` rises after the line strobe that makes the running count equal to `linesPerFrame - linesBefore + 1`. For example, with a captured length of 10 and `linesBefore` = 4, it rises on the 7th strobe.
- R6: In the first field after reset no early opening occurs; blanking starts at the vertical edge.
- R7: With `blankEn` = 0, `vblank` is 0 from the following cycle on.
- R8: Parity is sampled at the vertical rising edge. If `halfLine` = 0 the field is odd and `oddEven` becomes 1. If `halfLine` = 1 the field is even and `oddEven` becomes 0.
- R9: With `oeOnLead` = 0, `oddEven` takes the new parity on the cycle after the falling edge of `vsyncIn`. With `oeOnLead` = 1 it takes the new parity on the cycle after the rising edge. In all other cycles it holds.
- R10: With `progressive` = 1, `oddEven` is 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineStb | input | 1 | One-cycle qualified line strobe |
| vsyncIn | input | 1 | Vertical sync level, active high |
| halfLine | input | 1 | High when the current position is near mid-line |
| progressive | input | 1 | Source is progressive |
| blankEn | input | 1 | Enables blanking window generation |
| linesBefore | input | BEFORE_W | Lines the window opens before the vertical edge |
| linesAfter | input | AFTER_W | Lines the window stays open after the vertical edge |
| oeOnLead | input | 1 | 1: parity changes on the vsync rising edge; 0: on the falling edge |
| vblank | output | 1 | Vertical blanking window |
| oddEven | output | 1 | 1 in an odd field, 0 in an even field |
| linesPerFrame | output | CNT_W | Last captured line count |
| lpfUpdated | output | 1 | A new line count was captured |

## Verification
The bench builds the block with an 8-bit line counter and the default 4-bit and 7-bit window fields. The narrow counter makes saturation reachable within a few hundred line strobes, while the window fields still span the full ranges. Short frames of a few lines each then expose the predicted early opening, the first-field fallback, the zero-length after window and both parity edge modes. Each of these is checked on the exact cycle it should take effect.

// File: rtl/vfg_pkg.sv
`timescale 1ns/1ps
package vfg_pkg;
  // Strobes produced by the control side, consumed by the datapath
  typedef struct packed {
    logic lineTick;
    logic vLead;
    logic vTrail;
  } vfgStrobes_t;

  localparam int unsigned DEF_BEFORE = 4;
  localparam int unsigned DEF_AFTER  = 16;
endpackage

// File: rtl/vfg_datapath.sv
`timescale 1ns/1ps
module vfg_datapath
  import vfg_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned BEFORE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  vfgStrobes_t         stb,
  input  logic [BEFORE_W-1:0] linesBefore,
  output logic [CNT_W-1:0]    linesPerFrame,
  output logic                lpfUpdated,
  output logic                preHit
);
  localparam int unsigned EXT_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lineCnt;
  logic             prevValid;
  logic [CNT_W-1:0] capVal;
  logic [EXT_W-1:0] nxtExt, lhsExt, rhsExt;

  // Capture value includes a strobe landing in the edge cycle, saturated
  always_comb begin
    if (stb.lineTick && lineCnt != CNT_MAX) capVal = lineCnt + 1'b1;
    else                                   capVal = lineCnt;
  end

  always_comb begin
    nxtExt = EXT_W'(lineCnt) + EXT_W'(1);
    lhsExt = nxtExt + EXT_W'(linesBefore);
    rhsExt = EXT_W'(linesPerFrame) + EXT_W'(1);
    preHit = stb.lineTick && !stb.vLead && prevValid &&
             (linesBefore != '0) && (lhsExt == rhsExt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineCnt       <= '0;
      linesPerFrame <= '0;
      lpfUpdated    <= 1'b0;
      prevValid     <= 1'b0;
    end else if (stb.vLead) begin
      linesPerFrame <= capVal;
      lineCnt       <= '0;
      lpfUpdated    <= 1'b1;
      prevValid     <= 1'b1;
    end else if (stb.lineTick) begin
      lpfUpdated <= 1'b0;
      if (lineCnt != CNT_MAX) lineCnt <= lineCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vfg_ctrl.sv
`timescale 1ns/1ps
module vfg_ctrl
  import vfg_pkg::*;
#(
  parameter int unsigned AFTER_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lineStb,
  input  logic               vsyncIn,
  input  logic               halfLine,
  input  logic               progressive,
  input  logic               blankEn,
  input  logic [AFTER_W-1:0] linesAfter,
  input  logic               oeOnLead,
  input  logic               preHit,
  output vfgStrobes_t        stb,
  output logic               vblank,
  output logic               oddEven
);
  logic               vsPrev;
  logic [AFTER_W-1:0] afterCnt;
  logic               fieldOdd;

  always_comb begin
    stb.lineTick = lineStb;
    stb.vLead    = vsyncIn && !vsPrev;
    stb.vTrail   = !vsyncIn && vsPrev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vsPrev <= 1'b0;
    else        vsPrev <= vsyncIn;
  end

  // Blanking window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank   <= 1'b0;
      afterCnt <= '0;
    end else if (!blankEn) begin
      vblank   <= 1'b0;
      afterCnt <= '0;
    end else if (stb.vLead) begin
      vblank   <= (linesAfter != '0);
      afterCnt <= linesAfter;
    end else if (stb.lineTick) begin
      if (preHit)                        vblank <= 1'b1;
      else if (afterCnt == AFTER_W'(1))  vblank <= 1'b0;
      if (afterCnt != '0) afterCnt <= afterCnt - 1'b1;
    end
  end

  // Field parity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fieldOdd <= 1'b0;
      oddEven  <= 1'b0;
    end else begin
      if (stb.vLead) fieldOdd <= !halfLine;
      if (progressive)                 oddEven <= 1'b1;
      else if (oeOnLead && stb.vLead)  oddEven <= !halfLine;
      else if (!oeOnLead && stb.vTrail) oddEven <= fieldOdd;
    end
  end
endmodule

// File: rtl/vblank_field_gen.sv
`timescale 1ns/1ps
module vblank_field_gen
  import vfg_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned BEFORE_W = 4,
  parameter int unsigned AFTER_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lineStb,
  input  logic                vsyncIn,
  input  logic                halfLine,
  input  logic                progressive,
  input  logic                blankEn,
  input  logic [BEFORE_W-1:0] linesBefore,
  input  logic [AFTER_W-1:0]  linesAfter,
  input  logic                oeOnLead,
  output logic                vblank,
  output logic                oddEven,
  output logic [CNT_W-1:0]    linesPerFrame,
  output logic                lpfUpdated
);
  vfgStrobes_t stb;
  logic        preHit;

  vfg_ctrl #(.AFTER_W(AFTER_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .lineStb(lineStb), .vsyncIn(vsyncIn),
    .halfLine(halfLine), .progressive(progressive), .blankEn(blankEn),
    .linesAfter(linesAfter), .oeOnLead(oeOnLead), .preHit(preHit),
    .stb(stb), .vblank(vblank), .oddEven(oddEven)
  );

  vfg_datapath #(.CNT_W(CNT_W), .BEFORE_W(BEFORE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .linesBefore(linesBefore),
    .linesPerFrame(linesPerFrame), .lpfUpdated(lpfUpdated), .preHit(preHit)
  );
endmodule

// File: rtl/vfg_checker.sv
`timescale 1ns/1ps
module vfg_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lineStb,
  input logic             vsyncIn,
  input logic             progressive,
  input logic             blankEn,
  input logic             vblank,
  input logic             oddEven,
  input logic [CNT_W-1:0] linesPerFrame,
  input logic             lpfUpdated
);
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !blankEn |=> !vblank); // R7

  AST_PROG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    progressive |=> oddEven); // R10

  AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStb && !vsyncIn) |=> !lpfUpdated); // R2

  AST_LPF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vsyncIn |=> $stable(linesPerFrame)); // R2

  AST_ODD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vsyncIn == $past(vsyncIn) && !progressive) |=> $stable(oddEven)); // R9
endmodule

bind vblank_field_gen vfg_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lineStb(lineStb), .vsyncIn(vsyncIn),
  .progressive(progressive), .blankEn(blankEn), .vblank(vblank),
  .oddEven(oddEven), .linesPerFrame(linesPerFrame), .lpfUpdated(lpfUpdated)
);

// File: tb/vblank_field_gen_tb.sv
`timescale 1ns/1ps
module vblank_field_gen_tb_top;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned BW    = 4;
  localparam int unsigned AW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineStb = 1'b0, vsyncIn = 1'b0, halfLine = 1'b0;
  logic progressive = 1'b0, blankEn = 1'b1, oeOnLead = 1'b0;
  logic [BW-1:0] linesBefore = 4'd4;
  logic [AW-1:0] linesAfter = 7'd3;
  logic vblank, oddEven, lpfUpdated;
  logic [CNT_W-1:0] linesPerFrame;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  vblank_field_gen #(.CNT_W(CNT_W), .BEFORE_W(BW), .AFTER_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lineStb(lineStb), .vsyncIn(vsyncIn),
    .halfLine(halfLine), .progressive(progressive), .blankEn(blankEn),
    .linesBefore(linesBefore), .linesAfter(linesAfter), .oeOnLead(oeOnLead),
    .vblank(vblank), .oddEven(oddEven), .linesPerFrame(linesPerFrame),
    .lpfUpdated(lpfUpdated)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lineStb = 1'b1;
      @(negedge clk) lineStb = 1'b0;
    end
  endtask

  task automatic vsRise(input logic half);
    @(negedge clk) begin vsyncIn = 1'b1; halfLine = half; end
    @(negedge clk) halfLine = 1'b0;
  endtask

  task automatic vsFall();
    @(negedge clk) vsyncIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0; vsyncIn = 1'b0; lineStb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 vblank", vblank, 0);
    chk("R1 oddEven", oddEven, 0);
    chk("R1 linesPerFrame", linesPerFrame, 0);
    chk("R1 lpfUpdated", lpfUpdated, 0);
  endtask

  task automatic testFrames();
    blankEn = 1'b1; linesBefore = 4'd4; linesAfter = 7'd3; oeOnLead = 1'b0;
    lines(3);
    chk("R6 no early open", vblank, 0);
    vsRise(1'b0);
    chk("R2 capture 3", linesPerFrame, 3);
    chk("R2 updated set", lpfUpdated, 1);
    chk("R6 open at edge", vblank, 1);
    chk("R9 trailing mode holds at lead", oddEven, 0);
    vsFall();
    chk("R8 odd on start-of-line edge", oddEven, 1);
    lines(1);
    chk("R2 updated cleared", lpfUpdated, 0);
    lines(1);
    chk("R4 still open", vblank, 1);
    lines(1);
    chk("R4 closes after 3", vblank, 0);
    lines(7);
    vsRise(1'b1);
    chk("R2 capture 10", linesPerFrame, 10);
    chk("R9 holds until trailing", oddEven, 1);
    vsFall();
    chk("R8 even on mid-line edge", oddEven, 0);
    lines(6);
    chk("R5 not yet open at 6", vblank, 0);
    lines(1);
    chk("R5 opens at 7", vblank, 1);
    lines(3);
    vsRise(1'b0);
    chk("R4 open through edge", vblank, 1);
    chk("R2 capture 10 again", linesPerFrame, 10);
    vsFall();
  endtask

  task automatic testLeadMode();
    oeOnLead = 1'b1;
    lines(10);
    vsRise(1'b1);
    chk("R9 lead mode even", oddEven, 0);
    vsFall();
    chk("R9 lead mode stable at fall", oddEven, 0);
    lines(10);
    vsRise(1'b0);
    chk("R9 lead mode odd", oddEven, 1);
    vsFall();
    oeOnLead = 1'b0;
  endtask

  task automatic testAfterZero();
    linesAfter = 7'd0;
    lines(10);
    vsRise(1'b0);
    chk("R4 zero after closes at edge", vblank, 0);
    vsFall();
    lines(2);
    chk("R4 zero after stays closed", vblank, 0);
    linesAfter = 7'd3;
    vsRise(1'b0);
    vsFall();
  endtask

  task automatic testDisable();
    linesAfter = 7'd5;
    lines(4);
    vsRise(1'b0);
    chk("R4 open before disable", vblank, 1);
    @(negedge clk) blankEn = 1'b0;
    @(negedge clk);
    chk("R7 disabled closes", vblank, 0);
    vsFall();
    vsRise(1'b0);
    chk("R7 edge ignored", vblank, 0);
    vsFall();
    blankEn = 1'b1;
    linesAfter = 7'd3;
  endtask

  task automatic testProgressive();
    oeOnLead = 1'b1;
    lines(2);
    vsRise(1'b1);
    chk("R8 even before progressive", oddEven, 0);
    vsFall();
    @(negedge clk) progressive = 1'b1;
    @(negedge clk);
    chk("R10 forced high", oddEven, 1);
    vsRise(1'b1);
    chk("R10 high through mid-line edge", oddEven, 1);
    vsFall();
    progressive = 1'b0;
    oeOnLead = 1'b0;
  endtask

  task automatic testSaturate();
    lines(300);
    vsRise(1'b0);
    chk("R3 saturate at 255", linesPerFrame, 255);
    vsFall();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testFrames();
    testLeadMode();
    testAfterZero();
    testDisable();
    testProgressive();
    testSaturate();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule